// File: doc/BRIEF.md
# SPI Master with Register Port

This block is a serial peripheral interface master that a processor drives through a single 32-bit register port. Software writes bytes into a 128-entry transmit queue. The shift engine sends each byte most significant bit first on the serial data output. At the same time it collects one byte from the serial data input and stores it in a 128-entry receive queue, which software drains one byte per read.

A control register sets the clock polarity and phase, a divider code for the serial clock, and a four-line active-low device-select field. Two more control bits choose manual device select and manual start. Interrupt status bits, a mask register and a level interrupt output complete the block. There is also a general-purpose delay register. Its value is stored and read back, and it has no effect on timing.

Register byte offsets: 0x00 control, 0x04 status, 0x08 mask set, 0x0C mask clear, 0x10 mask readback, 0x14 enable, 0x18 delay, 0x1C transmit data, 0x20 receive data. Control fields: bit 0 master, bit 1 CPOL, bit 2 CPHA, bits 5:3 divider code, bits 13:10 device-select lines, bit 14 manual select, bit 15 manual start, and bit 16 a write-only start strobe. Status bits: 0 receive overflow (latched), 1 byte complete (latched), 2 transmit queue not full, 3 transmit queue full, 4 receive queue not empty, 5 receive queue full, 6 transmit overflow (latched).

Top module: `spi_master_regs`

## Requirements
- R1: After reset, control reads 0x3C00, status reads 0x04, the mask and the enable register read 0, cs_n is 4'hF, sclk is 0 and irq is 0.
- R2: The serial clock period is (2 << divider code) input clock cycles. Whenever no byte is in progress, sclk rests at the CPOL level.
- R3: Each queued byte produces 16 clock edges. MOSI carries the byte MSB first, and exactly one MISO byte is captured and queued. With CPHA=0, data is sampled on leading edges and changed on trailing edges; with CPHA=1, the two are swapped.
- R4: With enable bit 0 clear or control bit 0 clear, no serial clock edge occurs, and queued bytes stay queued.
- R5: With control bit 14 set, cs_n always equals control bits 13:10. With it clear, cs_n equals that field while a byte is shifting and is 4'hF otherwise.
- R6: With control bit 15 set, queued bytes wait until control is written with bit 16 set. The whole queue is then sent.
- R7: The transmit queue holds 128 bytes. A write to it while full is dropped, sets status bit 6 and clears status bit 2 / sets bit 3 while full.
- R8: Reading receive data pops one byte in arrival order, and a read of the empty queue returns 0. A byte that completes while the receive queue is full is dropped and sets status bit 0. Status bit 5 is set while full.
- R9: Status bit 1 latches when a byte completes, and status bit 4 is high exactly while the receive queue holds data.
- R10: Writing ones to the status register clears the matching latched bits (0, 1, 6).
- R11: Writing ones at 0x08 sets mask bits, writing ones at 0x0C clears them, and 0x10 reads the current mask.
- R12: irq is high exactly while some status bit is set that is also set in the mask.
- R13: The delay register reads back the last 32-bit value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register access strobe, one cycle per access |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the access cycle |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low device selects |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the control register is rewritten only while no byte is shifting. They also assume that MISO changes only on the edge opposite the sampling edge, as a correctly behaving slave would do. The bench keeps to both conditions. It clears the enable bit and switches its slave model off before every reconfiguration. The slave model moves its output only on the non-sampling edge for the chosen phase.

// File: rtl/spi_master_regs.sv
`timescale 1ns/1ps
module spi_master_regs #(
  parameter int FIFO_DEPTH = 128
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_sel,
  input  logic        reg_wr,
  input  logic [5:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic [3:0]  cs_n,
  output logic        irq
);
  localparam int AW = $clog2(FIFO_DEPTH);
  localparam int CW = AW + 1;
  localparam int HW = 8;
  localparam logic [CW-1:0] FULL = CW'(FIFO_DEPTH);
  localparam logic [15:0] CTRL_RST = 16'h3C00;
  localparam logic [15:0] CTRL_WMASK = 16'hFC3F;
  localparam logic [5:0] A_CTRL = 6'h00, A_STS = 6'h04, A_IEN = 6'h08, A_IDIS = 6'h0C,
                         A_MASK = 6'h10, A_EN = 6'h14, A_DLY = 6'h18, A_TX = 6'h1C, A_RX = 6'h20;

  logic [15:0] ctrl_q;
  logic        en_q, go_q;
  logic [6:0]  imr_q;
  logic [31:0] dly_q;
  logic        ovf_tx_q, ovf_rx_q, done_q;
  logic [7:0]  tx_mem [FIFO_DEPTH];
  logic [7:0]  rx_mem [FIFO_DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic        busy, sclk_q;
  logic [HW-1:0] hcnt;
  logic [3:0]  edge_cnt;
  logic [7:0]  tx_sh, rx_sh;

  logic wr_en, rd_en, tx_full, tx_empty, rx_full, rx_empty;
  logic tx_push, rx_push, rx_pop, start, tick, last, shift_e, samp_e, byte_done, run;
  logic cpol, cpha, man_cs, man_st;
  logic [HW-1:0] half;
  logic [7:0] rx_nx, rx_byte;
  logic [6:0] sts;

  assign wr_en = reg_sel & reg_wr;
  assign rd_en = reg_sel & ~reg_wr;
  assign cpol = ctrl_q[1];
  assign cpha = ctrl_q[2];
  assign man_cs = ctrl_q[14];
  assign man_st = ctrl_q[15];
  assign run = en_q & ctrl_q[0];
  assign half = HW'(1) << ctrl_q[5:3];

  assign tx_full  = tx_cnt == FULL;
  assign tx_empty = tx_cnt == '0;
  assign rx_full  = rx_cnt == FULL;
  assign rx_empty = rx_cnt == '0;

  assign tx_push = wr_en && reg_addr == A_TX && !tx_full;
  assign start   = run && !busy && !tx_empty && (!man_st || go_q);
  assign tick    = busy && run && hcnt == half - 1'b1;
  assign last    = edge_cnt == 4'd15;
  assign shift_e = cpha ? (!edge_cnt[0] && edge_cnt != 4'd0) : (edge_cnt[0] && !last);
  assign samp_e  = edge_cnt[0] == cpha;
  assign rx_nx   = {rx_sh[6:0], miso};
  assign byte_done = tick && last;
  assign rx_byte = samp_e ? rx_nx : rx_sh;
  assign rx_push = byte_done && !rx_full;
  assign rx_pop  = rd_en && reg_addr == A_RX && !rx_empty;

  assign sclk = busy ? sclk_q : cpol;
  assign mosi = tx_sh[7];
  assign cs_n = (man_cs || busy) ? ctrl_q[13:10] : 4'hF;

  assign sts = {ovf_tx_q, rx_full, !rx_empty, tx_full, !tx_full, done_q, ovf_rx_q};
  assign irq = |(sts & imr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      en_q <= 1'b0;
      go_q <= 1'b0;
      imr_q <= '0;
      dly_q <= '0;
    end else if (wr_en) begin
      case (reg_addr)
        A_CTRL: begin
          ctrl_q <= reg_wdata[15:0] & CTRL_WMASK;
          if (reg_wdata[16]) go_q <= 1'b1;
        end
        A_IEN:  imr_q <= imr_q | reg_wdata[6:0];
        A_IDIS: imr_q <= imr_q & ~reg_wdata[6:0];
        A_EN:   en_q <= reg_wdata[0];
        A_DLY:  dly_q <= reg_wdata;
        default: ;
      endcase
    end else if (!busy && tx_empty) begin
      go_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_tx_q <= 1'b0;
      ovf_rx_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (wr_en && reg_addr == A_STS) begin
        if (reg_wdata[6]) ovf_tx_q <= 1'b0;
        if (reg_wdata[1]) done_q <= 1'b0;
        if (reg_wdata[0]) ovf_rx_q <= 1'b0;
      end
      if (wr_en && reg_addr == A_TX && tx_full) ovf_tx_q <= 1'b1;
      if (byte_done) done_q <= 1'b1;
      if (byte_done && rx_full) ovf_rx_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (start)   tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(start);
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= reg_wdata[7:0];
    if (rx_push) rx_mem[rx_wp] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sclk_q <= 1'b0;
      hcnt <= '0;
      edge_cnt <= '0;
      tx_sh <= '0;
      rx_sh <= '0;
    end else if (start) begin
      busy <= 1'b1;
      sclk_q <= cpol;
      hcnt <= '0;
      edge_cnt <= '0;
      tx_sh <= tx_mem[tx_rp];
    end else if (tick) begin
      hcnt <= '0;
      sclk_q <= ~sclk_q;
      edge_cnt <= edge_cnt + 1'b1;
      if (shift_e) tx_sh <= {tx_sh[6:0], 1'b0};
      if (samp_e) rx_sh <= rx_nx;
      if (last) busy <= 1'b0;
    end else if (busy && run) begin
      hcnt <= hcnt + 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL: reg_rdata = {16'h0, ctrl_q};
      A_STS:  reg_rdata = {25'h0, sts};
      A_MASK: reg_rdata = {25'h0, imr_q};
      A_EN:   reg_rdata = {31'h0, en_q};
      A_DLY:  reg_rdata = dly_q;
      A_RX:   reg_rdata = rx_empty ? 32'h0 : {24'h0, rx_mem[rx_rp]};
      default: reg_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/spi_master_regs_chk.sv
`timescale 1ns/1ps
module spi_master_regs_chk #(
  parameter int DEPTH = 128,
  parameter int CW = 8
)(
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          run,
  input logic          sclk,
  input logic          cpol,
  input logic [3:0]    cs_n,
  input logic [3:0]    cs_field,
  input logic          man_cs,
  input logic          man_st,
  input logic          go_q,
  input logic          irq,
  input logic [6:0]    imr,
  input logic [CW-1:0] tx_cnt
);
  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> sclk == cpol);
  // R5
  cs_manual_chk: assert property (@(posedge clk) disable iff (!rst_n) man_cs |-> cs_n == cs_field);
  // R5
  cs_auto_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) (!man_cs && !busy) |-> cs_n == 4'hF);
  // R4
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n) (!run && busy) |=> $stable(sclk));
  // R6
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) ($rose(busy) && $past(man_st)) |-> $past(go_q));
  // R7
  tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= CW'(DEPTH));
  // R12
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n) (imr == 7'h0) |-> !irq);
endmodule

bind spi_master_regs spi_master_regs_chk #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .run(run), .sclk(sclk), .cpol(cpol),
  .cs_n(cs_n), .cs_field(ctrl_q[13:10]), .man_cs(man_cs), .man_st(man_st),
  .go_q(go_q), .irq(irq), .imr(imr_q), .tx_cnt(tx_cnt)
);

// File: tb/spi_master_regs_bench.sv
`timescale 1ns/1ps
module spi_master_regs_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_sel = 1'b0, reg_wr = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic sclk, mosi, miso;
  logic [3:0] cs_n;
  logic irq;

  int total = 0, bad = 0;
  bit finished = 0;

  // slave model state
  bit slave_on = 0, s_cpol = 0, s_cpha = 0;
  logic [7:0] s_out = '0, s_in = '0;
  int s_bits = 0, s_k = 0, e_cnt = 0, cap_n = 0, cs_bad = 0;
  logic [3:0] exp_cs = 4'hF;
  logic [7:0] cap [256];
  realtime t0 = 0, t1 = 0;

  always #2 clk = ~clk;

  spi_master_regs u_spi_master_regs (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi), .miso(miso),
    .cs_n(cs_n), .irq(irq)
  );

  assign miso = s_out[7];

  function automatic logic [7:0] pat(int k);
    return 8'(k * 37 + 5);
  endfunction

  function automatic logic [7:0] txb(int m, int d, int i);
    return 8'(161 + m * 53 + d * 29 + i * 91);
  endfunction

  task automatic s_capture();
    s_in = {s_in[6:0], mosi};
    s_bits++;
    if (s_bits == 8) begin
      cap[cap_n % 256] = s_in;
      cap_n++;
      s_bits = 0;
      if (s_cpha) begin s_k++; s_out = pat(s_k); end
    end
  endtask

  always @(sclk) begin
    if (slave_on) begin
      e_cnt++;
      if (sclk !== s_cpol) begin
        if (e_cnt == 1) t0 = $realtime;
        if (e_cnt == 3) t1 = $realtime;
        if (cs_n !== exp_cs) cs_bad++;
        if (!s_cpha) s_capture();
        else if (s_bits != 0) s_out = s_out << 1;
      end else begin
        if (!s_cpha) begin
          if (s_bits == 0) begin s_k++; s_out = pat(s_k); end
          else s_out = s_out << 1;
        end else s_capture();
      end
    end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_sel = 1'b0;
  endtask

  task automatic slave_reset(bit pol, bit pha);
    s_cpol = pol; s_cpha = pha; s_bits = 0; s_k = 0; s_out = pat(0);
    e_cnt = 0; cap_n = 0; cs_bad = 0;
  endtask

  task automatic wait_edges(int n);
    int guard = 0;
    while (e_cnt < n && guard < 40000) begin
      @(negedge clk);
      guard++;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic run_xfer(int m, int d, int n, bit man);
    logic [31:0] v;
    logic [3:0] cs = man ? 4'b1101 : 4'b1110;
    logic [31:0] ctrl = 32'h1 | (32'(m[1]) << 1) | (32'(m[0]) << 2) | (32'(d) << 3)
                        | (32'(cs) << 10) | (32'(man) << 14);
    slave_on = 0;
    wr(6'h14, 0);
    wr(6'h00, ctrl);
    slave_reset(m[1], m[0]);
    exp_cs = cs;
    slave_on = 1;
    for (int i = 0; i < n; i++) wr(6'h1C, 32'(txb(m, d, i)));
    if (man) chk("R5 manual select while idle", 32'(cs_n), 32'(cs));
    wr(6'h14, 1);
    wait_edges(16 * n);
    chk("R3 edge count", e_cnt, 16 * n);
    chk("R2 sclk period ps", 32'(int'((t1 - t0) * 1000)), 32'((2 << d) * 4000));
    chk("R5 select during bytes", cs_bad, 0);
    chk("R5 select after bytes", 32'(cs_n), man ? 32'(cs) : 32'hF);
    chk("R2 idle level", 32'(sclk), 32'(m[1]));
    rd(6'h04, v);
    chk("R9 done latched", 32'(v[1]), 1);
    chk("R9 rx not empty", 32'(v[4]), 1);
    for (int i = 0; i < n; i++) begin
      rd(6'h20, v);
      chk("R3 miso byte", v, 32'(pat(i)));
      chk("R3 mosi byte", 32'(cap[i]), 32'(txb(m, d, i)));
    end
    wr(6'h04, 32'h2);
    rd(6'h04, v);
    chk("R10 done cleared", 32'(v[1]), 0);
    chk("R9 rx empty after drain", 32'(v[4]), 0);
  endtask

  initial begin
    repeat (160000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    rd(6'h00, v); chk("R1 ctrl reset", v, 32'h3C00);
    rd(6'h04, v); chk("R1 status reset", v, 32'h04);
    rd(6'h10, v); chk("R1 mask reset", v, 0);
    rd(6'h14, v); chk("R1 enable reset", v, 0);
    chk("R1 pins", {26'h0, cs_n, sclk, irq}, {26'h0, 4'hF, 1'b0, 1'b0});

    // R13
    wr(6'h18, 32'hA5A5_5A5A);
    rd(6'h18, v); chk("R13 delay readback", v, 32'hA5A5_5A5A);

    // R2 R3 R5 sweep over modes and divider codes
    for (int m = 0; m < 4; m++)
      for (int d = 0; d < 4; d++)
        run_xfer(m, d, 3, (d == 2));
    run_xfer(0, 7, 1, 0);

    // R4 enable clear, then master bit clear
    slave_on = 0; wr(6'h14, 0); wr(6'h00, 32'h0000_3801);
    slave_reset(0, 0); exp_cs = 4'b1110; slave_on = 1;
    wr(6'h1C, 32'h5A); wr(6'h1C, 32'h3C);
    repeat (60) @(negedge clk);
    chk("R4 no edges while disabled", e_cnt, 0);
    wr(6'h00, 32'h0000_3800); wr(6'h14, 1);
    repeat (60) @(negedge clk);
    chk("R4 no edges without master", e_cnt, 0);
    rd(6'h04, v); chk("R4 nothing received", 32'(v[4]), 0);

    // R6 manual start
    wr(6'h14, 0); wr(6'h00, 32'h0000_B801); wr(6'h14, 1);
    repeat (60) @(negedge clk);
    chk("R6 held before strobe", e_cnt, 0);
    wr(6'h00, 32'h0001_B801);
    wait_edges(32);
    chk("R6 whole queue sent", e_cnt, 32);
    chk("R6 first byte out", 32'(cap[0]), 32'h5A);
    chk("R6 second byte out", 32'(cap[1]), 32'h3C);
    rd(6'h20, v); chk("R6 first byte in", v, 32'(pat(0)));
    rd(6'h20, v); chk("R6 second byte in", v, 32'(pat(1)));
    // R8 empty read
    rd(6'h20, v); chk("R8 empty read is zero", v, 0);

    // R11 R12 masks and interrupt
    wr(6'h04, 32'h7F);
    wr(6'h08, 32'h12);
    rd(6'h10, v); chk("R11 mask set", v, 32'h12);
    chk("R12 irq low, masked bits clear", 32'(irq), 0);
    wr(6'h0C, 32'h02);
    rd(6'h10, v); chk("R11 mask clear", v, 32'h10);

    // R7 transmit overflow
    slave_on = 0; wr(6'h14, 0); wr(6'h00, 32'h0000_3801);
    for (int i = 0; i < 128; i++) wr(6'h1C, 32'(pat(i + 3)));
    rd(6'h04, v);
    chk("R7 full flag", 32'(v[3]), 1);
    chk("R7 not-full flag low", 32'(v[2]), 0);
    chk("R7 no overflow yet", 32'(v[6]), 0);
    wr(6'h1C, 32'hEE);
    rd(6'h04, v); chk("R7 overflow latched", 32'(v[6]), 1);
    wr(6'h04, 32'h40);
    rd(6'h04, v); chk("R10 overflow cleared", 32'(v[6]), 0);

    // R8 receive full and overflow
    slave_reset(0, 0); exp_cs = 4'b1110; slave_on = 1;
    wr(6'h14, 1);
    wait_edges(16 * 128);
    chk("R7 128 bytes sent", cap_n, 128);
    chk("R7 last byte kept", 32'(cap[127]), 32'(pat(130)));
    chk("R12 irq on rx data", 32'(irq), 1);
    rd(6'h04, v);
    chk("R8 rx full", 32'(v[5]), 1);
    chk("R8 no rx overflow yet", 32'(v[0]), 0);
    wr(6'h1C, 32'h77);
    wait_edges(16 * 129);
    rd(6'h04, v); chk("R8 rx overflow latched", 32'(v[0]), 1);
    for (int i = 0; i < 128; i++) begin
      rd(6'h20, v);
      if (i == 0 || i == 127) chk("R8 arrival order", v, 32'(pat(i)));
    end
    rd(6'h20, v); chk("R8 empty after drain", v, 0);
    chk("R12 irq falls when rx empty", 32'(irq), 0);
    wr(6'h08, 32'h01);
    chk("R12 irq on rx overflow", 32'(irq), 1);
    wr(6'h04, 32'h01);
    chk("R10 rx overflow clear drops irq", 32'(irq), 0);
    finish_run();
  end
endmodule